// File: doc/BRIEF.md
# Machine-Check Error Logging Bank

This block holds one bank of error-logging state for a processor's machine-check facility. There are three 64-bit registers: a status word, an error address and a word of extra information. A hardware logging port posts an error in a single cycle. The post carries a code, an address-valid flag, an extra-information-valid flag, a two-bit health code with a monitored indication, an address and the extra word. A second error that arrives while an earlier one is still held only marks an overflow, so the first record survives until software takes it.

Software reaches the bank through a simple register port. On a request the port picks one register, reads it or writes it, and the reply comes back combinationally in the same cycle. The address and extra-information registers can only be cleared, by writing all zeros. Any other write to them is refused, and so is any access to a register that the configuration leaves out. A refused access raises a one-cycle fault pulse and changes no state. Parameters decide whether the address and extra-information registers exist and whether the address is 36 or 64 bits wide.

Top module: `err_bank`

## Requirements
- R1: After reset, all three registers read as zero and the fault output is low.
- R2: A log posted while the valid bit (status bit 63) is clear loads all three registers at one clock edge. In status it sets bit 63, clears bit 62, copies the address-valid flag to bit 58 and the extra-valid flag to bit 59, and places the code in bits 15:0. All of this is readable in the next cycle.
- R3: If the logged error is not from a monitored structure, status bits 54:53 read 00 whatever health code was offered. If it is monitored, the offered code is stored there.
- R4: A log posted while bit 63 is set sets the overflow bit 62. Every other status field, the address register and the extra register keep their earlier content.
- R5: A software write to status (select 0) stores the written value masked to bits 63, 62, 59, 58, 54:53 and 15:0, with all other bits zero. Writing zero clears the valid bit.
- R6: Writing all zeros to an implemented address (select 1) or extra register (select 2) clears it, with no fault.
- R7: Writing a value with any 1 bit to the address or extra register raises the fault and leaves the register unchanged.
- R8: When a register is configured absent, any read or write to it raises the fault and returns zero read data.
- R9: With a 36-bit address, bits 63:36 of the address register always read zero and a logged address keeps only bits 35:0.
- R10: The fault output is high only in a cycle that carries an offending request, in that same cycle. Select 3 is reserved and always faults. Reads of implemented registers never fault.
- R11: If a log loads an empty bank in the same cycle as a software write, the log wins and the software write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_valid | input | 1 | Hardware posts an error this cycle |
| log_addr_ok | input | 1 | Posted address is meaningful |
| log_misc_ok | input | 1 | Posted extra word is meaningful |
| log_monitored | input | 1 | Error comes from a monitored structure |
| log_health | input | 2 | Health code for monitored errors |
| log_code | input | 16 | Error code for status bits 15:0 |
| log_addr | input | 64 | Error address |
| log_misc | input | 64 | Extra error information |
| sw_req | input | 1 | Software access this cycle |
| sw_we | input | 1 | Access is a write |
| sw_sel | input | 2 | Register select: 0 status, 1 address, 2 extra, 3 reserved |
| sw_wdata | input | 64 | Write data |
| sw_rdata | output | 64 | Read data, zero on a faulting access |
| sw_fault | output | 1 | Protection-fault pulse |

## Verification
The hardest case to reach is a log and a software write landing in the same cycle while the bank is empty, because random traffic seldom lines the two up. A directed step clears status and then drives both in one cycle, and the random phase keeps logs frequent enough to hit it again. Overflow needs a second log before software has cleared the first. Directed steps create it deliberately, and the random phase, which clears status rarely, reaches it often. A second instance with a narrow address and no extra register runs on the same stimulus, which covers the absent-register and truncation paths.

// File: rtl/err_bank_pkg.sv
package err_bank_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_MISC = 2'd2,
      SEL_RSVD = 2'd3
   } reg_sel_e;

   localparam int unsigned REG_W     = 64;
   localparam int unsigned CODE_W    = 16;
   localparam int unsigned BIT_VAL   = 63;
   localparam int unsigned BIT_OVF   = 62;
   localparam int unsigned BIT_MISCV = 59;
   localparam int unsigned BIT_ADDRV = 58;
   localparam int unsigned HLTH_HI   = 54;
   localparam int unsigned HLTH_LO   = 53;
   localparam logic [REG_W-1:0] STAT_MASK = 64'hCC60_0000_0000_FFFF;
endpackage

// File: rtl/err_status_reg.sv
module err_status_reg
   import err_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              log_take,
   input  logic              log_addr_ok,
   input  logic              log_misc_ok,
   input  logic              log_monitored,
   input  logic [1:0]        log_health,
   input  logic [CODE_W-1:0] log_code,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  stat_q,
   output logic              loaded
);
   logic [REG_W-1:0] built;
   logic [REG_W-1:0] stat_d;
   logic             held;

   assign held   = stat_q[BIT_VAL];
   assign loaded = log_take & ~held;

   always_comb begin
      built                   = '0;
      built[BIT_VAL]          = 1'b1;
      built[BIT_MISCV]        = log_misc_ok;
      built[BIT_ADDRV]        = log_addr_ok;
      built[HLTH_HI:HLTH_LO]  = log_monitored ? log_health : 2'b00;
      built[CODE_W-1:0]       = log_code;
   end

   always_comb begin
      stat_d = stat_q;
      if (log_take) begin
         if (!held) stat_d = built;
         else       stat_d[BIT_OVF] = 1'b1;
      end else if (wr_en) begin
         stat_d = wdata & STAT_MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assert_load_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (log_take && !stat_q[BIT_VAL]) |=> (stat_q[BIT_VAL] && !stat_q[BIT_OVF]));

   assert_unmonitored_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (log_take && !stat_q[BIT_VAL] && !log_monitored) |=> (stat_q[HLTH_HI:HLTH_LO] == 2'b00));

   assert_overflow_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (log_take && stat_q[BIT_VAL]) |=> (stat_q[BIT_OVF] && stat_q[BIT_VAL]));

   assert_overflow_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (log_take && stat_q[BIT_VAL]) |=>
         ($stable(stat_q[BIT_MISCV:BIT_ADDRV]) && $stable(stat_q[CODE_W-1:0])
          && $stable(stat_q[HLTH_HI:HLTH_LO])));
endmodule

// File: rtl/err_aux_reg.sv
module err_aux_reg
   import err_bank_pkg::*;
#(
   parameter bit          IMPL   = 1'b1,
   parameter int unsigned KEEP_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REG_W-1:0] load_data,
   input  logic             hit,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             fault
);
   if (KEEP_W != 36 && KEEP_W != 64) begin : g_bad_width
      $error("err_aux_reg: KEEP_W must be 36 or 64");
   end

   if (IMPL) begin : g_impl
      logic [KEEP_W-1:0] q;
      logic              nonzero;
      logic              clear;
      logic              unused_load_hi;

      assign unused_load_hi = ^load_data;
      assign nonzero = |wdata;
      assign fault   = hit & we & nonzero;
      assign clear   = hit & we & ~nonzero & ~load;
      assign rdata   = REG_W'(q);

      always_ff @(posedge clk) begin
         if (!rst_n)     q <= '0;
         else if (load)  q <= load_data[KEEP_W-1:0];
         else if (clear) q <= '0;
      end

      assert_zero_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && we && (wdata == '0) && !load) |=> (q == '0));

      assert_nonzero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && we && (wdata != '0) && !load) |=> $stable(q));

      assert_nonzero_write_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && we && (wdata != '0)) |-> fault);

      assert_upper_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (KEEP_W == 36) |-> (rdata[REG_W-1:36] == '0));
   end else begin : g_absent
      logic unused_inputs;
      assign unused_inputs = ^{load, load_data, we, wdata, clk, rst_n};
      assign rdata = '0;
      assign fault = hit;
   end
endmodule

// File: rtl/err_bank.sv
module err_bank
   import err_bank_pkg::*;
#(
   parameter bit          ADDR_IMPL = 1'b1,
   parameter bit          MISC_IMPL = 1'b1,
   parameter int unsigned ADDR_BITS = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        log_valid,
   input  logic        log_addr_ok,
   input  logic        log_misc_ok,
   input  logic        log_monitored,
   input  logic [1:0]  log_health,
   input  logic [15:0] log_code,
   input  logic [63:0] log_addr,
   input  logic [63:0] log_misc,
   input  logic        sw_req,
   input  logic        sw_we,
   input  logic [1:0]  sw_sel,
   input  logic [63:0] sw_wdata,
   output logic [63:0] sw_rdata,
   output logic        sw_fault
);
   localparam int unsigned MISC_BITS = REG_W;

   if (ADDR_BITS != 36 && ADDR_BITS != 64) begin : g_bad_addr
      $error("err_bank: ADDR_BITS must be 36 or 64");
   end

   reg_sel_e         sel;
   logic [REG_W-1:0] stat_q;
   logic [REG_W-1:0] addr_rd;
   logic [REG_W-1:0] misc_rd;
   logic             addr_flt;
   logic             misc_flt;
   logic             rsvd_flt;
   logic             loaded;
   logic             stat_wr;

   assign sel      = reg_sel_e'(sw_sel);
   assign stat_wr  = sw_req & sw_we & (sel == SEL_STAT);
   assign rsvd_flt = sw_req & (sel == SEL_RSVD);

   err_status_reg u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .log_take      (log_valid),
      .log_addr_ok   (log_addr_ok),
      .log_misc_ok   (log_misc_ok),
      .log_monitored (log_monitored),
      .log_health    (log_health),
      .log_code      (log_code),
      .wr_en         (stat_wr),
      .wdata         (sw_wdata),
      .stat_q        (stat_q),
      .loaded        (loaded)
   );

   err_aux_reg #(.IMPL(ADDR_IMPL), .KEEP_W(ADDR_BITS)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (loaded),
      .load_data (log_addr),
      .hit       (sw_req && sel == SEL_ADDR),
      .we        (sw_we),
      .wdata     (sw_wdata),
      .rdata     (addr_rd),
      .fault     (addr_flt)
   );

   err_aux_reg #(.IMPL(MISC_IMPL), .KEEP_W(MISC_BITS)) u_misc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (loaded),
      .load_data (log_misc),
      .hit       (sw_req && sel == SEL_MISC),
      .we        (sw_we),
      .wdata     (sw_wdata),
      .rdata     (misc_rd),
      .fault     (misc_flt)
   );

   assign sw_fault = addr_flt | misc_flt | rsvd_flt;

   always_comb begin
      sw_rdata = '0;
      if (!sw_fault) begin
         unique case (sel)
            SEL_STAT: sw_rdata = stat_q;
            SEL_ADDR: sw_rdata = addr_rd;
            SEL_MISC: sw_rdata = misc_rd;
            default:  sw_rdata = '0;
         endcase
      end
   end

   assert_fault_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sw_fault |-> sw_req);

   assert_status_read_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && !sw_we && sel == SEL_STAT) |-> !sw_fault);

   assert_absent_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_fault |-> (sw_rdata == '0));

   assert_log_beats_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (log_valid && !stat_q[BIT_VAL] && stat_wr) |=> stat_q[BIT_VAL]);
endmodule

// File: tb/err_bank_bench.sv
module err_bank_bench;
   localparam logic [63:0] SMASK = 64'hCC60_0000_0000_FFFF;
   localparam logic [63:0] NMASK = 64'h0000_000F_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        log_valid = 0, log_addr_ok = 0, log_misc_ok = 0, log_monitored = 0;
   logic [1:0]  log_health = 0;
   logic [15:0] log_code = 0;
   logic [63:0] log_addr = 0, log_misc = 0;
   logic        sw_req = 0, sw_we = 0;
   logic [1:0]  sw_sel = 0;
   logic [63:0] sw_wdata = 0;
   logic [63:0] rd0, rd1;
   logic        f0, f1;

   int checks = 0;
   int errors = 0;
   bit strict = 0;
   bit done = 0;
   logic [63:0] m_stat [2];
   logic [63:0] m_addr [2];
   logic [63:0] m_misc [2];

   always #2 clk = ~clk;

   err_bank u_err_bank (
      .clk(clk), .rst_n(rst_n), .log_valid(log_valid), .log_addr_ok(log_addr_ok),
      .log_misc_ok(log_misc_ok), .log_monitored(log_monitored), .log_health(log_health),
      .log_code(log_code), .log_addr(log_addr), .log_misc(log_misc), .sw_req(sw_req),
      .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(rd0), .sw_fault(f0));

   err_bank #(.ADDR_IMPL(1'b1), .MISC_IMPL(1'b0), .ADDR_BITS(36)) u_err_bank_alt (
      .clk(clk), .rst_n(rst_n), .log_valid(log_valid), .log_addr_ok(log_addr_ok),
      .log_misc_ok(log_misc_ok), .log_monitored(log_monitored), .log_health(log_health),
      .log_code(log_code), .log_addr(log_addr), .log_misc(log_misc), .sw_req(sw_req),
      .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(rd1), .sw_fault(f1));

   function automatic bit exp_fault(int i);
      if (!sw_req) return 1'b0;
      case (sw_sel)
         2'd0:    return 1'b0;
         2'd1:    return sw_we && sw_wdata != 0;
         2'd2:    return (i == 1) ? 1'b1 : (sw_we && sw_wdata != 0);
         default: return 1'b1;
      endcase
   endfunction

   function automatic string tag_of(int i);
      if (sw_sel == 2'd3) return "R10";
      if (sw_sel == 2'd2 && i == 1) return "R8";
      if (sw_we && sw_sel != 2'd0) return (sw_wdata != 0) ? "R7" : "R6";
      if (sw_we) return "R5";
      if (sw_sel == 2'd1 && i == 1) return "R9";
      return "R2";
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_now(string force_tag);
      for (int i = 0; i < 2; i++) begin
         logic [63:0] rd;
         logic        fl;
         bit          ef;
         string       tg;
         rd = (i == 0) ? rd0 : rd1;
         fl = (i == 0) ? f0 : f1;
         ef = exp_fault(i);
         tg = (force_tag != "") ? force_tag : tag_of(i);
         chk(tg, {63'd0, fl}, {63'd0, ef});
         if (sw_req && !sw_we) begin
            if (ef) chk(tg, rd, 64'd0);
            else if (sw_sel == 2'd0) begin
               if (strict || m_stat[i][63]) chk(tg, rd, m_stat[i]);
               else chk(tg, {63'd0, rd[63]}, 64'd0);
            end else if (sw_sel == 2'd1) begin
               if (strict || m_stat[i][58]) chk(tg, rd, m_addr[i]);
            end else if (sw_sel == 2'd2) begin
               if (strict || m_stat[i][59]) chk(tg, rd, m_misc[i]);
            end
         end
      end
   endtask

   task automatic model_step();
      for (int i = 0; i < 2; i++) begin
         bit take;
         take = log_valid && !m_stat[i][63];
         if (log_valid) begin
            if (take) begin
               logic [63:0] b;
               b = '0;
               b[63] = 1'b1;
               b[59] = log_misc_ok;
               b[58] = log_addr_ok;
               b[54:53] = log_monitored ? log_health : 2'b00;
               b[15:0] = log_code;
               m_stat[i] = b;
               m_addr[i] = (i == 1) ? (log_addr & NMASK) : log_addr;
               m_misc[i] = (i == 1) ? 64'd0 : log_misc;
            end else m_stat[i][62] = 1'b1;
         end else if (sw_req && sw_we && sw_sel == 2'd0) begin
            m_stat[i] = sw_wdata & SMASK;
         end
         if (!take && sw_req && sw_we && sw_wdata == 0) begin
            if (sw_sel == 2'd1) m_addr[i] = 0;
            if (sw_sel == 2'd2 && i == 0) m_misc[i] = 0;
         end
      end
   endtask

   task automatic step(bit lv, bit aok, bit mok, bit mon, logic [1:0] hl, logic [15:0] code,
                       logic [63:0] la, logic [63:0] lm, bit req, bit we, logic [1:0] sel,
                       logic [63:0] wd, string tg);
      @(negedge clk);
      log_valid = lv; log_addr_ok = aok; log_misc_ok = mok; log_monitored = mon;
      log_health = hl; log_code = code; log_addr = la; log_misc = lm;
      sw_req = req; sw_we = we; sw_sel = sel; sw_wdata = wd;
      #1;
      check_now(tg);
      model_step();
   endtask

   task automatic rd(logic [1:0] sel, string tg);
      step(0, 0, 0, 0, 2'b00, 16'h0, 64'h0, 64'h0, 1, 0, sel, 64'h0, tg);
   endtask

   task automatic wr(logic [1:0] sel, logic [63:0] wd, string tg);
      step(0, 0, 0, 0, 2'b00, 16'h0, 64'h0, 64'h0, 1, 1, sel, wd, tg);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_stat[i] = 0; m_addr[i] = 0; m_misc[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      strict = 1;
      step(0, 0, 0, 0, 2'b00, 16'h0, 64'h0, 64'h0, 0, 0, 2'd0, 64'h0, "R1");
      rd(2'd0, "R1");
      rd(2'd1, "R1");
      step(0, 0, 0, 0, 2'b00, 16'h0, 64'h0, 64'h0, 1, 0, 2'd2, 64'h0, "");

      step(1, 1, 1, 0, 2'b10, 16'hBEEF, 64'hFEDC_BA98_7654_3210, 64'h1111_2222_3333_4444,
           0, 0, 2'd0, 64'h0, "R2");
      rd(2'd0, "R3");
      rd(2'd1, "");
      rd(2'd2, "");
      wr(2'd2, 64'h0, "");
      step(1, 0, 0, 1, 2'b01, 16'h1234, 64'h55, 64'h66, 0, 0, 2'd0, 64'h0, "R4");
      rd(2'd0, "R4");
      rd(2'd1, "R4");
      wr(2'd1, 64'h0000_0000_0000_0100, "R7");
      rd(2'd1, "R7");
      wr(2'd1, 64'h0, "R6");
      rd(2'd1, "R6");
      wr(2'd2, 64'h8000_0000_0000_0000, "");
      rd(2'd2, "");
      wr(2'd2, 64'h0, "");
      rd(2'd2, "");
      rd(2'd3, "R10");
      wr(2'd3, 64'h0, "R10");
      wr(2'd0, 64'h0, "R5");
      rd(2'd0, "R5");
      wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
      rd(2'd0, "R5");
      wr(2'd0, 64'h0, "R5");
      step(1, 1, 0, 1, 2'b11, 16'h00A5, 64'hABCD_0000_1234_5678, 64'h77, 1, 1, 2'd0,
           64'h0, "R11");
      rd(2'd0, "R11");
      rd(2'd1, "R9");
      wr(2'd0, 64'h0, "R5");
      step(1, 1, 1, 1, 2'b10, 16'h0F0F, 64'h99, 64'h88, 1, 1, 2'd1, 64'h0, "R11");
      rd(2'd1, "R11");
      strict = 0;

      void'($urandom(32'd1234));
      for (int n = 0; n < 600; n++) begin
         logic [63:0] wd;
         logic [1:0]  sel;
         sel = 2'($urandom);
         wd = ($urandom % 3 == 0) ? 64'h0 : {$urandom, $urandom};
         if (sel == 2'd0 && $urandom % 4 != 0) wd = 64'h0;
         step(($urandom % 4) == 0, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
              16'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              ($urandom % 4) != 0, ($urandom % 3) == 0, sel, wd, "");
      end

      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule